// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block derives the two external-bus strobes of a controller core whose machine cycle lasts twelve oscillator clocks: an address-latch strobe (`ale`, active high) and a program-store read strobe (`psen_n`, active low). A tick counter divides each machine cycle into six states of two phases. The strobes are decoded from that counter and come straight out of flip-flops. The block also reports the current state and phase, so the surrounding core can line its own timing up with the bus.

The core tells the block what each machine cycle is doing. Four controls do this: execution from external program memory, an external data-memory transfer, an external code-table read, and a software bit that turns the address-latch strobe off. These controls are sampled once, at the start of a machine cycle, and then govern that whole cycle.

A data transfer removes the first address-latch pulse and both read pulses of its cycle. The software disable parks the address-latch strobe high, except in transfer or table-read cycles. The disable is ignored while code runs from external memory. The raw reset input must stay high for two full machine cycles before it takes effect. Shorter glitches are filtered out.

Top module: `bus_strobe_gen`

## Requirements
- R1: A reset request takes effect only after `rst` has been sampled high on 2 machine cycles (24) of consecutive rising edges. The strobes then go inactive on the following edge. A pulse of 23 or fewer edges leaves the tick sequence and the strobes running unchanged.
- R2: While the qualified reset is in effect, `ale` is 0, `psen_n` is 1, `mc_state` is 0 and `mc_phase` is 0.
- R3: Tick numbers run 0 to 11, with tick = 2*state + phase. State 0 is the first state and phase 0 is the first phase. After every edge the reported tick advances by one and wraps from 11 to 0. On release of a qualified reset, tick 0 is reported after the first edge that samples `rst` low, and tick 1 after the next edge.
- R4: In a cycle with no data transfer and no disable in force, `ale` is 1 exactly on ticks 1, 2, 7 and 8. That is two pulses per twelve clocks.
- R5: In a cycle with `ext_exec`=1 and no data transfer, `psen_n` is 0 exactly on ticks 3, 4, 5, 9, 10 and 11.
- R6: In a cycle with `ext_exec`=0, `psen_n` stays 1 on every tick.
- R7: In a cycle with `xdata_cyc`=1, the first `ale` pulse (ticks 1 and 2) is omitted, the second is kept, and `psen_n` stays 1.
- R8: With `ale_off`=1 and `ext_exec`=0, `ale` is 1 on all twelve ticks of a cycle that has neither `xdata_cyc` nor `code_rd_cyc`. A cycle that has either one shows the pattern of R4, with R7 applied when `xdata_cyc`=1.
- R9: With `ext_exec`=1, `ale_off` has no effect on `ale`.
- R10: The four controls are sampled only on the edge that yields tick 0. A change at any other tick has no effect until the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Raw reset request, active high, qualified internally |
| ext_exec | input | 1 | Core executes from external program memory |
| xdata_cyc | input | 1 | Coming machine cycle is an external data transfer |
| code_rd_cyc | input | 1 | Coming machine cycle is an external code-table read |
| ale_off | input | 1 | Software address-latch strobe disable |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| mc_state | output | SW ($clog2(STATES)) | Current state within the machine cycle, 0-based |
| mc_phase | output | PW ($clog2(PHASES)) | Current phase within the state, 0-based |

## Verification
The bench uses the default build: six states of two phases and a two-cycle reset hold. At that size, every one of the sixteen control combinations can be run for a full machine cycle and checked on all twelve ticks. In each of those cycles the controls are scrambled halfway through, which shows the sampling point. The small hold count lets the bench put a 23-edge glitch and a 24-edge reset right at the qualification threshold. It then checks both the idle state that follows and the restart at tick 0.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  // Controls that hold for one whole machine cycle
  typedef struct packed {
    logic ext;   // executing from external program memory
    logic xdat;  // external data transfer in this cycle
    logic crd;   // external code-table read in this cycle
    logic aoff;  // software strobe disable
  } cyc_ctl_t;

  // True when tick tk lies in [lo, lo+len)
  function automatic logic tick_in(input int tk, input int lo, input int len);
    return (tk >= lo) && (tk < lo + len);
  endfunction

endpackage

// File: rtl/bsg_rst_qual.sv
module bsg_rst_qual #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst,
  output logic rst_q
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] hold_cnt;

  // Count consecutive high samples; assert once the count is reached
  always_ff @(posedge clk) begin
    if (!rst) begin
      hold_cnt <= '0;
      rst_q    <= 1'b0;
    end else begin
      if (hold_cnt != CW'(HOLD)) hold_cnt <= hold_cnt + 1'b1;
      rst_q <= (hold_cnt >= CW'(HOLD - 1));
    end
  end
endmodule

// File: rtl/bsg_tick_ctr.sv
module bsg_tick_ctr #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int TICKS = STATES * PHASES,
  localparam int TW    = $clog2(TICKS),
  localparam int SW    = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst_q,
  output logic [TW-1:0] tick_nxt,
  output logic          wrap_nxt,
  output logic [SW-1:0] mc_state,
  output logic [PW-1:0] mc_phase
);
  logic [TW-1:0] tick;

  always_comb begin
    if (rst_q || tick == TW'(TICKS - 1)) tick_nxt = '0;
    else                                  tick_nxt = tick + 1'b1;
  end

  assign wrap_nxt = (tick_nxt == '0);

  // State and phase are registered from the next tick so they line up with it
  always_ff @(posedge clk) begin
    tick     <= tick_nxt;
    mc_state <= SW'(tick_nxt / TW'(PHASES));
    mc_phase <= PW'(tick_nxt % TW'(PHASES));
  end
endmodule

// File: rtl/bsg_ctl_latch.sv
module bsg_ctl_latch
  import bsg_pkg::*;
(
  input  logic     clk,
  input  logic     wrap_nxt,
  input  cyc_ctl_t ctl_in,
  output cyc_ctl_t ctl_nxt
);
  cyc_ctl_t ctl;

  // Controls are taken only on the edge that starts a machine cycle
  assign ctl_nxt = wrap_nxt ? ctl_in : ctl;

  always_ff @(posedge clk) ctl <= ctl_nxt;
endmodule

// File: rtl/bsg_strobe_gen.sv
module bsg_strobe_gen
  import bsg_pkg::*;
#(
  parameter int TICKS      = 12,
  parameter int HALVES     = 2,
  parameter int ALE_START  = 1,
  parameter int ALE_LEN    = 2,
  parameter int PSEN_LEN   = 3,
  localparam int TW        = $clog2(TICKS),
  localparam int HALF      = TICKS / HALVES,
  localparam int PSEN_START = ALE_START + ALE_LEN
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic [TW-1:0] tick_nxt,
  input  cyc_ctl_t      ctl_nxt,
  output logic          ale,
  output logic          psen_n
);
  int                tk;
  logic [HALVES-1:0] ale_hit;
  logic [HALVES-1:0] ale_skip;
  logic [HALVES-1:0] psen_hit;
  logic              ale_park;
  logic              ale_d;
  logic              psen_fire;

  assign tk = int'(tick_nxt);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam int ALO = h * HALF + ALE_START;
    localparam int PLO = h * HALF + PSEN_START;
    assign ale_hit[h]  = tick_in(tk, ALO, ALE_LEN);
    assign psen_hit[h] = tick_in(tk, PLO, PSEN_LEN);
    if (h == 0) begin : g_first
      assign ale_skip[h] = ctl_nxt.xdat;  // transfer drops the first pulse
    end else begin : g_rest
      assign ale_skip[h] = 1'b0;
    end
  end

  // Disable parks ALE high unless the cycle needs the bus, and is void in external execution
  assign ale_park  = ctl_nxt.aoff && !ctl_nxt.ext && !ctl_nxt.xdat && !ctl_nxt.crd;
  assign ale_d     = ale_park || (|(ale_hit & ~ale_skip));
  assign psen_fire = ctl_nxt.ext && !ctl_nxt.xdat && (|psen_hit);

  always_ff @(posedge clk) begin
    if (rst_q) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
    end else begin
      ale    <= ale_d;
      psen_n <= !psen_fire;
    end
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int STATES      = 6,
  parameter int PHASES      = 2,
  parameter int RST_HOLD_MC = 2,
  parameter int ALE_START   = 1,
  parameter int ALE_LEN     = 2,
  parameter int PSEN_LEN    = 3,
  localparam int TICKS = STATES * PHASES,
  localparam int TW    = $clog2(TICKS),
  localparam int SW    = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int HOLD  = RST_HOLD_MC * TICKS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_exec,
  input  logic          xdata_cyc,
  input  logic          code_rd_cyc,
  input  logic          ale_off,
  output logic          ale,
  output logic          psen_n,
  output logic [SW-1:0] mc_state,
  output logic [PW-1:0] mc_phase
);
  logic          rst_q;
  logic [TW-1:0] tick_nxt;
  logic          wrap_nxt;
  cyc_ctl_t      ctl_in;
  cyc_ctl_t      ctl_nxt;

  assign ctl_in = '{ext: ext_exec, xdat: xdata_cyc, crd: code_rd_cyc, aoff: ale_off};

  bsg_rst_qual #(.HOLD(HOLD)) u_rst_qual (
    .clk   (clk),
    .rst   (rst),
    .rst_q (rst_q)
  );

  bsg_tick_ctr #(.STATES(STATES), .PHASES(PHASES)) u_tick_ctr (
    .clk      (clk),
    .rst_q    (rst_q),
    .tick_nxt (tick_nxt),
    .wrap_nxt (wrap_nxt),
    .mc_state (mc_state),
    .mc_phase (mc_phase)
  );

  bsg_ctl_latch u_ctl_latch (
    .clk      (clk),
    .wrap_nxt (wrap_nxt),
    .ctl_in   (ctl_in),
    .ctl_nxt  (ctl_nxt)
  );

  bsg_strobe_gen #(
    .TICKS     (TICKS),
    .HALVES    (2),
    .ALE_START (ALE_START),
    .ALE_LEN   (ALE_LEN),
    .PSEN_LEN  (PSEN_LEN)
  ) u_strobe_gen (
    .clk      (clk),
    .rst_q    (rst_q),
    .tick_nxt (tick_nxt),
    .ctl_nxt  (ctl_nxt),
    .ale      (ale),
    .psen_n   (psen_n)
  );
endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
  parameter int STATES    = 6,
  parameter int PHASES    = 2,
  parameter int HOLD      = 24,
  parameter int ALE_START = 1,
  parameter int ALE_LEN   = 2,
  parameter int PSEN_LEN  = 3,
  localparam int SW = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int CW = $clog2(HOLD + 1),
  localparam int HALF = (STATES * PHASES) / 2,
  localparam int PSEN_START = ALE_START + ALE_LEN
) (
  input logic          clk,
  input logic          rst,
  input logic          rst_q,
  input logic          ale,
  input logic          psen_n,
  input logic [SW-1:0] mc_state,
  input logic [PW-1:0] mc_phase
);
  logic          armed;
  logic [CW-1:0] hc;
  int            tk;
  logic          psen_ok;
  logic          rise_ok;

  always_ff @(posedge clk) begin
    armed <= armed | !rst;
    if (!rst)                  hc <= '0;
    else if (hc != CW'(HOLD))  hc <= hc + 1'b1;
  end

  assign tk      = int'(mc_state) * PHASES + int'(mc_phase);
  assign psen_ok = ((tk % HALF) >= PSEN_START) && ((tk % HALF) < PSEN_START + PSEN_LEN);
  assign rise_ok = (tk == 0) || ((tk % HALF) == ALE_START);

  // R1: a request shorter than the hold window does not disturb the tick sequence
  assert_short_glitch_R1: assert property (@(posedge clk) disable iff (!armed)
    (rst && hc < CW'(HOLD - 1) && mc_phase == PW'(PHASES - 1)) |=> (mc_phase == '0));

  // R2: qualified reset forces idle strobes and tick 0
  assert_reset_idle_R2: assert property (@(posedge clk) disable iff (!armed)
    rst_q |=> (!ale && psen_n && mc_state == '0 && mc_phase == '0));

  // R3: after the last phase of a state the next state follows, wrapping at the end
  assert_state_step_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (mc_phase == PW'(PHASES - 1)) |=>
      (mc_phase == '0 &&
       mc_state == (($past(mc_state) == SW'(STATES - 1)) ? '0 : $past(mc_state) + 1'b1)));

  // R4: the address strobe rises only at a pulse start or at a cycle start
  assert_ale_rise_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(ale) |-> rise_ok);

  // R5: the read strobe is low only inside its windows
  assert_psen_window_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    !psen_n |-> psen_ok);

  // R5: the two strobes are never active together
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    !(ale && !psen_n));
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(
  .STATES    (STATES),
  .PHASES    (PHASES),
  .HOLD      (HOLD),
  .ALE_START (ALE_START),
  .ALE_LEN   (ALE_LEN),
  .PSEN_LEN  (PSEN_LEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rst_q    (rst_q),
  .ale      (ale),
  .psen_n   (psen_n),
  .mc_state (mc_state),
  .mc_phase (mc_phase)
);

// File: tb/bus_strobe_gen_bench.sv
module bus_strobe_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_exec = 1'b0, xdata_cyc = 1'b0, code_rd_cyc = 1'b0, ale_off = 1'b0;
  logic       ale, psen_n;
  logic [2:0] mc_state;
  logic [0:0] mc_phase;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // cfg bits: [3] ext_exec, [2] xdata_cyc, [1] code_rd_cyc, [0] ale_off
  logic [3:0] cur_cfg = '0;
  logic [3:0] next_cfg = '0;
  int         t = 0;
  bit         idle = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_strobe_gen u_bus_strobe_gen (
    .clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_cyc(xdata_cyc),
    .code_rd_cyc(code_rd_cyc), .ale_off(ale_off), .ale(ale), .psen_n(psen_n),
    .mc_state(mc_state), .mc_phase(mc_phase)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0d cfg=%b actual=%0d expected=%0d", req, t, cur_cfg, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c);
    ext_exec = c[3]; xdata_cyc = c[2]; code_rd_cyc = c[1]; ale_off = c[0];
  endtask

  function automatic int exp_ale(input logic [3:0] c, input int tk);
    if (c[0] && !c[3] && !c[2] && !c[1]) return 1;
    if (c[2] && tk < 6) return 0;
    return ((tk % 6) == 1 || (tk % 6) == 2) ? 1 : 0;
  endfunction

  function automatic int exp_psen(input logic [3:0] c, input int tk);
    return (c[3] && !c[2] && (tk % 6) >= 3) ? 0 : 1;
  endfunction

  function automatic string ale_tag(input logic [3:0] c);
    if (c[0] && !c[3] && !c[2] && !c[1]) return "R8";
    if (c[0] && c[3]) return "R9";
    if (c[2]) return "R7";
    return "R4";
  endfunction

  function automatic string psen_tag(input logic [3:0] c);
    if (!c[3]) return "R6";
    if (c[2]) return "R7";
    return "R5";
  endfunction

  // One clock: sample mid-cycle, compare, then apply mid-cycle scrambling or next controls
  task automatic step();
    string sfx;
    @(posedge clk);
    @(negedge clk);
    sfx = (t >= 6) ? "/R10" : "";
    if (idle) begin
      check("R2 ale", int'(ale), 0);
      check("R2 psen_n", int'(psen_n), 1);
      check("R2 state", int'(mc_state), 0);
      check("R2 phase", int'(mc_phase), 0);
    end else begin
      check({ale_tag(cur_cfg), sfx, " ale"}, int'(ale), exp_ale(cur_cfg, t));
      check({psen_tag(cur_cfg), sfx, " psen_n"}, int'(psen_n), exp_psen(cur_cfg, t));
      check("R3 state", int'(mc_state), t / 2);
      check("R3 phase", int'(mc_phase), t % 2);
      if (t == 5) drive(~cur_cfg);
      if (t == 11) begin
        cur_cfg = next_cfg;
        drive(cur_cfg);
      end
      t = (t + 1) % 12;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    drive(4'b0000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    // R2: reset state after a long initial reset
    check("R2 ale", int'(ale), 0);
    check("R2 psen_n", int'(psen_n), 1);
    check("R2 state", int'(mc_state), 0);
    check("R2 phase", int'(mc_phase), 0);

    // R3: release; the next edge yields tick 0
    cur_cfg = 4'd0;
    drive(cur_cfg);
    rst = 1'b0;
    t = 0;

    // R4..R10: all 16 control combinations, each for one machine cycle
    for (int c = 0; c < 16; c++) begin
      next_cfg = 4'((c + 1) % 16);
      for (int k = 0; k < 12; k++) step();
    end

    // R1: a 23-edge request is filtered out
    next_cfg = 4'b1000;
    rst = 1'b1;
    for (int k = 0; k < 23; k++) step();
    rst = 1'b0;
    for (int k = 0; k < 13; k++) step();

    // R1: a 24-edge request is honoured, effective on the 25th edge
    next_cfg = 4'b1001;
    rst = 1'b1;
    for (int k = 0; k < 24; k++) step();
    idle = 1;
    for (int k = 0; k < 4; k++) step();

    // R3: restart at tick 0 after release, external execution with disable set (R9)
    cur_cfg = 4'b1001;
    next_cfg = 4'b1001;
    drive(cur_cfg);
    rst = 1'b0;
    idle = 0;
    t = 0;
    for (int k = 0; k < 24; k++) step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule